// File: doc/BRIEF.md
# Beam-Loss Threshold Comparator

This block judges running-sum loss values against per-detector limits and raises beam-dump requests. Each incoming sum carries its detector channel and window index. The block picks a limit from an internal table using the channel, the present beam-energy level and the window index. Short windows use 32-bit limits and long windows use 64-bit limits. A per-channel right-shift count can lower the limit, but it can never raise it. A sum strictly above its effective limit is an exceedance.

A per-channel masking table routes each exceedance. A channel can be connected or not connected. A connected channel can be maskable or unmaskable. Unmaskable channels always drive the unmaskable dump request. Maskable channels drive the maskable request only while the external mask input is low. Both requests latch until a clear pulse. A saturating counter records every request event.

At start-up, software fills the tables through a write port while the configuration-mode input is high. Comparisons are suppressed while that input is high.

Top module: `thr_guard`

## Requirements
- R1: While and after asynchronous active-low reset, `dump_unmaskable` and `dump_maskable` are 0 and `dump_count` is 0. The shift counts and the connected and maskable flags all reset to 0.
- R2: An accepted sum raises a request only when `sum_val` is strictly greater than the effective limit. A value equal to the limit raises nothing. The outputs update at the clock edge that samples `sum_valid`.
- R3: The limit is the entry for (`sum_ch`, `energy_lvl`, `sum_idx`). Window indices 0 to 7 read a 32-bit entry that is zero-extended. Indices 8 to 11 read a 64-bit entry.
- R4: The effective limit is the table entry shifted right by the channel's shift count.
- R5: An exceedance on a connected channel whose maskable flag is 0 sets `dump_unmaskable`, whatever the level of `mask_en`.
- R6: An exceedance on a connected, maskable channel sets `dump_maskable` only while `mask_en` is 0. With `mask_en` at 1 it sets neither output and is not counted.
- R7: A channel whose connected flag is 0 never raises a request.
- R8: Each request stays at 1 until a cycle with `dump_clr` high and no new request on that output. If a new request and `dump_clr` arrive in the same cycle, the request wins.
- R9: `dump_count` adds 1 for each sum that sets a request, whether or not that request was already set. It saturates at its all-ones value. `dump_clr` does not change it.
- R10: Table writes take effect only in cycles where `cfg_mode` and `wr_en` are both high. The `wr_sel` field selects the target: 0 writes a limit at (`wr_ch`, `wr_lvl`, `wr_sum`); 1 writes the shift count from `wr_data[5:0]`; 2 writes connected from `wr_data[0]` and maskable from `wr_data[1]`. Sums arriving while `cfg_mode` is high, or with `sum_idx` of 12 or more, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode: enables writes and suppresses comparisons |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Write target: 0 limit, 1 shift, 2 mask flags |
| wr_ch | input | 4 | Write channel |
| wr_lvl | input | 5 | Write energy level |
| wr_sum | input | 4 | Write window index |
| wr_data | input | 64 | Write data |
| energy_lvl | input | 5 | Current beam-energy level |
| sum_valid | input | 1 | Sum value present |
| sum_ch | input | 4 | Channel of the sum |
| sum_idx | input | 4 | Window index of the sum |
| sum_val | input | 64 | Running-sum value |
| mask_en | input | 1 | Masking active for maskable channels |
| dump_clr | input | 1 | Clears latched requests |
| dump_unmaskable | output | 1 | Latched unmaskable dump request |
| dump_maskable | output | 1 | Latched maskable dump request |
| dump_count | output | 16 | Saturating count of request events |

## Verification
The bench drives sums equal to a limit and one above it. A design that compares with greater-or-equal would dump on the equal value. It also drives a long-window sum above 2^32 that sits just on either side of its 64-bit limit. A design that truncated the long-window limits to 32 bits would misjudge that sum.

A scaled channel is tested at the shifted boundary. This catches a design that shifts the wrong way, or that ignores the shift.

Further stimulus covers masked and unmasked routing, channels that are not connected, writes made outside configuration mode, sums sent during configuration mode, and a clear arriving in the same cycle as a new request. Each of these catches a design that drops a request or raises a false one. A long run of exceedances pushes the counter to its ceiling, which exposes a counter that wraps instead of saturating.

// File: rtl/thr_guard.sv
module thr_guard #(
  parameter int NCH  = 16,
  parameter int NLVL = 32,
  parameter int NSUM = 12,
  parameter int NNAR = 8,
  parameter int NARW = 32,
  parameter int WIDW = 64,
  parameter int SHW  = 6,
  parameter int CNTW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_mode,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [$clog2(NCH)-1:0]    wr_ch,
  input  logic [$clog2(NLVL)-1:0]   wr_lvl,
  input  logic [$clog2(NSUM)-1:0]   wr_sum,
  input  logic [WIDW-1:0]           wr_data,
  input  logic [$clog2(NLVL)-1:0]   energy_lvl,
  input  logic                      sum_valid,
  input  logic [$clog2(NCH)-1:0]    sum_ch,
  input  logic [$clog2(NSUM)-1:0]   sum_idx,
  input  logic [WIDW-1:0]           sum_val,
  input  logic                      mask_en,
  input  logic                      dump_clr,
  output logic                      dump_unmaskable,
  output logic                      dump_maskable,
  output logic [CNTW-1:0]           dump_count
);
  localparam int SXW   = $clog2(NSUM);
  localparam int NWID  = NSUM - NNAR;
  localparam int NAR_D = NCH * NLVL * NNAR;
  localparam int WID_D = NCH * NLVL * NWID;
  localparam int NAW   = $clog2(NAR_D);
  localparam int WAW   = $clog2(WID_D);
  localparam logic [1:0] SEL_LIM = 2'd0;
  localparam logic [1:0] SEL_SHF = 2'd1;
  localparam logic [1:0] SEL_MSK = 2'd2;

  logic [NARW-1:0] nar_tab [NAR_D];
  logic [WIDW-1:0] wid_tab [WID_D];
  logic [SHW-1:0]  shamt   [NCH];
  logic [NCH-1:0]  conn_q, mskbl_q;

  logic            wr_ok, w_wide, w_inrng;
  logic [NAW-1:0]  w_nadr, r_nadr;
  logic [WAW-1:0]  w_wadr, r_wadr;
  logic            r_wide, accept, hit, trig_u, trig_m;
  logic [WIDW-1:0] raw_lim, eff_lim;

  assign wr_ok   = cfg_mode && wr_en;
  assign w_wide  = wr_sum >= SXW'(NNAR);
  assign w_inrng = wr_sum < SXW'(NSUM);
  assign w_nadr  = NAW'((int'(wr_ch) * NLVL + int'(wr_lvl)) * NNAR + int'(wr_sum));
  assign w_wadr  = WAW'((int'(wr_ch) * NLVL + int'(wr_lvl)) * NWID + int'(wr_sum) - NNAR);

  always_ff @(posedge clk) begin
    if (wr_ok && wr_sel == SEL_LIM && w_inrng) begin
      if (w_wide) wid_tab[w_wadr] <= wr_data;
      else        nar_tab[w_nadr] <= wr_data[NARW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) shamt[i] <= '0;
      conn_q  <= '0;
      mskbl_q <= '0;
    end else if (wr_ok) begin
      if (wr_sel == SEL_SHF) shamt[wr_ch] <= wr_data[SHW-1:0];
      if (wr_sel == SEL_MSK) begin
        conn_q[wr_ch]  <= wr_data[0];
        mskbl_q[wr_ch] <= wr_data[1];
      end
    end
  end

  assign r_wide  = sum_idx >= SXW'(NNAR);
  assign r_nadr  = NAW'((int'(sum_ch) * NLVL + int'(energy_lvl)) * NNAR + int'(sum_idx));
  assign r_wadr  = WAW'((int'(sum_ch) * NLVL + int'(energy_lvl)) * NWID + int'(sum_idx) - NNAR);
  assign raw_lim = r_wide ? wid_tab[r_wadr] : WIDW'(nar_tab[r_nadr]);
  assign eff_lim = raw_lim >> shamt[sum_ch];

  assign accept = sum_valid && !cfg_mode && (sum_idx < SXW'(NSUM)) && conn_q[sum_ch];
  assign hit    = accept && (sum_val > eff_lim);
  assign trig_u = hit && !mskbl_q[sum_ch];
  assign trig_m = hit && mskbl_q[sum_ch] && !mask_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dump_unmaskable <= 1'b0;
      dump_maskable   <= 1'b0;
      dump_count      <= '0;
    end else begin
      if (trig_u)        dump_unmaskable <= 1'b1;
      else if (dump_clr) dump_unmaskable <= 1'b0;
      if (trig_m)        dump_maskable   <= 1'b1;
      else if (dump_clr) dump_maskable   <= 1'b0;
      if ((trig_u || trig_m) && dump_count != '1)
        dump_count <= dump_count + 1'b1;
    end
  end
endmodule

module thr_guard_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_mode,
  input logic            sum_valid,
  input logic            dump_clr,
  input logic            dump_unmaskable,
  input logic            dump_maskable,
  input logic [CNTW-1:0] dump_count
);
  p_hold_u_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_unmaskable && !dump_clr) |=> dump_unmaskable);
  p_hold_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_maskable && !dump_clr) |=> dump_maskable);
  p_rise_u_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_unmaskable) |-> $past(sum_valid && !cfg_mode));
  p_rise_m_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_maskable) |-> $past(sum_valid && !cfg_mode));
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dump_count == $past(dump_count) || dump_count == $past(dump_count) + 1'b1));
  p_cfg_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> $stable(dump_count));
  p_cnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_count != $past(dump_count)) |-> (dump_unmaskable || dump_maskable));
endmodule

bind thr_guard thr_guard_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .sum_valid(sum_valid),
  .dump_clr(dump_clr), .dump_unmaskable(dump_unmaskable),
  .dump_maskable(dump_maskable), .dump_count(dump_count)
);

// File: tb/tb_thr_guard.sv
module tb_thr_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [3:0]  wr_ch = '0;
  logic [4:0]  wr_lvl = '0;
  logic [3:0]  wr_sum = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  energy_lvl = '0;
  logic        sum_valid = 1'b0;
  logic [3:0]  sum_ch = '0, sum_idx = '0;
  logic [63:0] sum_val = '0;
  logic        mask_en = 1'b0, dump_clr = 1'b0;
  logic        dump_unmaskable, dump_maskable;
  logic [15:0] dump_count;

  int total = 0, bad = 0, exp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  thr_guard dut (.*);

  typedef struct packed {
    logic [4:0]  lvl;
    logic [3:0]  ch;
    logic [3:0]  idx;
    logic [63:0] val;
    logic        msk;
    logic        eu;
    logic        em;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'd3, 4'd0, 4'd0, 64'd1000,          1'b0, 1'b0, 1'b0},
    '{5'd3, 4'd0, 4'd0, 64'd1001,          1'b0, 1'b1, 1'b0},
    '{5'd4, 4'd0, 4'd0, 64'd51,            1'b0, 1'b1, 1'b0},
    '{5'd4, 4'd0, 4'd0, 64'd50,            1'b0, 1'b0, 1'b0},
    '{5'd3, 4'd0, 4'd9, 64'hFFFF_FFFF,     1'b0, 1'b0, 1'b0},
    '{5'd3, 4'd0, 4'd9, 64'h1_0000_0001,   1'b0, 1'b1, 1'b0},
    '{5'd3, 4'd3, 4'd0, 64'd251,           1'b0, 1'b1, 1'b0},
    '{5'd3, 4'd3, 4'd0, 64'd250,           1'b0, 1'b0, 1'b0},
    '{5'd3, 4'd1, 4'd0, 64'd2000,          1'b0, 1'b0, 1'b1},
    '{5'd3, 4'd1, 4'd0, 64'd2000,          1'b1, 1'b0, 1'b0},
    '{5'd3, 4'd0, 4'd0, 64'd2000,          1'b1, 1'b1, 1'b0},
    '{5'd3, 4'd2, 4'd0, 64'd99,            1'b0, 1'b0, 1'b0}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] ch, input logic [4:0] lvl,
                    input logic [3:0] sm, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_ch = ch; wr_lvl = lvl; wr_sum = sm; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [4:0] lvl, input logic [3:0] ch, input logic [3:0] idx,
                      input logic [63:0] v, input logic m, input logic clr);
    @(negedge clk);
    energy_lvl = lvl; sum_ch = ch; sum_idx = idx; sum_val = v; mask_en = m;
    sum_valid = 1'b1; dump_clr = clr;
    @(negedge clk);
    sum_valid = 1'b0; dump_clr = 1'b0; mask_en = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); dump_clr = 1'b1;
    @(negedge clk); dump_clr = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dump_unmaskable, 0, "R1 unmaskable in reset");
    check(dump_count, 0, "R1 count in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check({dump_maskable, dump_unmaskable}, 0, "R1 requests after reset");

    cfg_mode = 1'b1;
    wr(2'd0, 4'd0, 5'd3, 4'd0, 64'd1000);
    wr(2'd0, 4'd0, 5'd4, 4'd0, 64'd50);
    wr(2'd0, 4'd0, 5'd3, 4'd9, 64'h1_0000_0000);
    wr(2'd0, 4'd1, 5'd3, 4'd0, 64'd1000);
    wr(2'd0, 4'd2, 5'd3, 4'd0, 64'd10);
    wr(2'd0, 4'd3, 5'd3, 4'd0, 64'd1000);
    wr(2'd1, 4'd3, 5'd0, 4'd0, 64'd2);
    wr(2'd2, 4'd0, 5'd0, 4'd0, 64'd1);
    wr(2'd2, 4'd1, 5'd0, 4'd0, 64'd3);
    wr(2'd2, 4'd2, 5'd0, 4'd0, 64'd2);
    wr(2'd2, 4'd3, 5'd0, 4'd0, 64'd1);
    cfg_mode = 1'b0;

    // R2 R3 R4 R5 R6 R7: table-driven vectors
    for (int i = 0; i < NV; i++) begin
      clear();
      send(VEC[i].lvl, VEC[i].ch, VEC[i].idx, VEC[i].val, VEC[i].msk, 1'b0);
      if (VEC[i].eu || VEC[i].em) exp_cnt++;
      check({dump_unmaskable, dump_maskable}, {VEC[i].eu, VEC[i].em},
            $sformatf("R2-vector %0d requests (R3 R4 R5 R6 R7)", i));
    end
    check(dump_count, exp_cnt, "R9 count after vectors");

    // R8: latch and clear
    clear();
    send(5'd3, 4'd0, 4'd0, 64'd5000, 1'b0, 1'b0); exp_cnt++;
    repeat (3) @(negedge clk);
    check(dump_unmaskable, 1, "R8 request held");
    clear();
    check(dump_unmaskable, 0, "R8 request cleared");
    check(dump_count, exp_cnt, "R9 count unaffected by clear");
    send(5'd3, 4'd0, 4'd0, 64'd5000, 1'b0, 1'b1); exp_cnt++;
    check(dump_unmaskable, 1, "R8 set wins over clear");
    clear();
    send(5'd3, 4'd1, 4'd0, 64'd5000, 1'b0, 1'b0); exp_cnt++;
    repeat (2) @(negedge clk);
    check(dump_maskable, 1, "R8 maskable held");
    clear();
    check(dump_maskable, 0, "R8 maskable cleared");

    // R10: write outside config mode ignored
    wr(2'd0, 4'd0, 5'd3, 4'd0, 64'd5);
    send(5'd3, 4'd0, 4'd0, 64'd6, 1'b0, 1'b0);
    check(dump_unmaskable, 0, "R10 write outside cfg ignored");
    cfg_mode = 1'b1;
    send(5'd3, 4'd0, 4'd0, 64'd5000, 1'b0, 1'b0);
    check({dump_unmaskable, dump_maskable}, 0, "R10 sum during cfg ignored");
    cfg_mode = 1'b0;
    send(5'd3, 4'd0, 4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    check(dump_unmaskable, 0, "R10 out-of-range index ignored");
    check(dump_count, exp_cnt, "R10 count unchanged");

    // R9: saturation
    @(negedge clk);
    energy_lvl = 5'd3; sum_ch = 4'd0; sum_idx = 4'd0; sum_val = 64'd5000; sum_valid = 1'b1;
    repeat (65600) @(negedge clk);
    sum_valid = 1'b0;
    @(negedge clk);
    check(dump_count, 16'hFFFF, "R9 count saturates");

    done = 1;
    summary();
    $finish;
  end
endmodule